// File: doc/BRIEF.md
# Serial Flash Paired-Byte Program Sequencer

This block sits on the host side of a four-wire serial flash link and writes a run of consecutive byte pairs using the flash's auto-incrementing word-program mode. A client gives an even 24-bit start address, a word count and a busy-wait limit, then pulses `start`. It then delivers 16-bit words over a valid/ready handshake. The block generates every bus frame on its own. It first turns on ready/busy reporting on the flash data-out line and sets the write-enable latch. It then sends one addressed program frame followed by address-less program frames, waits for the flash between words, and finally sends write-disable.

Between frames the block does not read the status register. It holds chip select low with the clock idle and samples the flash data-out pin, which reads 0 while the flash is busy and 1 once it is ready. Each such wait has an upper bound in system clocks. If a wait runs past that bound, the run is abandoned with write-disable and an error. Requests the flash could not honour are refused before any bus activity. A request is refused if the start address is odd, the count is zero, or the run would run past the top of the address space.

Top module: `flash_pair_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `error` and `wdata_ready` are 0.
- R2: An accepted run sends its commands as separate chip-select frames in this order: 0x70 (ready/busy on data-out), 0x06 (write enable), the program frames, then 0x04 (write disable).
- R3: The first program frame is 0xAD, then the 24 address bits (bit 23 first), then two data bytes, every byte most significant bit first. `wdata[15:8]` is written to the even address and `wdata[7:0]` to the odd address that follows.
- R4: Each later word goes out as a 24-bit frame: 0xAD followed by the two data bytes, with no address. The flash places it at the next two addresses.
- R5: The bus uses SPI mode 0. `spi_sck` rests low and is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low. Each high phase of `spi_sck` lasts CLK_DIV system clocks.
- R6: After every program frame, and after write-disable, the block drops `spi_cs_n` without clocking. It starts no new frame and does not raise `done` until it has sampled `spi_miso` as 1.
- R7: `wdata_ready` is high only while `spi_cs_n` is high and the block is waiting for a word. A program frame starts only after its word has been accepted.
- R8: A request is refused with `done` and `error` and no chip-select activity if any of these holds: the address is odd, the count is zero, or the address plus twice the count exceeds 2^24. A run that ends exactly at the top address is accepted.
- R9: If a busy wait after a program frame lasts `busy_limit` cycles without ready, the block sends write-disable. It then raises `done` with `error` without waiting again.
- R10: `done` is a single-cycle pulse that ends each request. `error` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| start_addr | input | 24 | First byte address, must be even |
| word_count | input | CNT_W | Number of 16-bit words to write |
| busy_limit | input | TO_W | Longest busy wait in system clocks |
| wdata | input | 16 | Word to write, high byte to the even address |
| wdata_valid | input | 1 | `wdata` holds a word |
| wdata_ready | output | 1 | Block takes the word this cycle |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Request refused or timed out, valid with `done` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data and ready/busy from the flash |

## Verification
The bench builds the block with CLK_DIV = 2, CNT_W = 8 and TO_W = 12. These values keep bytes short, so full multi-word runs finish quickly and the measured clock high time can be compared against a small known value. A narrow count field is enough to reach the top-of-space boundary from address 0xFFFFFE and the overflow case from 0xFFFFFC. The short timeout width puts a limit of 100 cycles within reach, so a flash held busy for 400 cycles exercises the abandon path in a few hundred cycles.

// File: rtl/flash_pair_pkg.sv
// Shared command codes and state encodings for the paired-byte flash writer.
package flash_pair_pkg;

    localparam int ADDR_W  = 24;
    localparam int FRAME_W = 8 + ADDR_W + 16;

    localparam logic [7:0] CMD_WR_ON   = 8'h06;
    localparam logic [7:0] CMD_WR_OFF  = 8'h04;
    localparam logic [7:0] CMD_PAIR    = 8'hAD;
    localparam logic [7:0] CMD_RB_LINE = 8'h70;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_SHIFT, S_END, S_FETCH, S_POLL, S_DONE
    } wr_state_t;

    typedef enum logic [1:0] {
        STEP_RB, STEP_WREN, STEP_PROG, STEP_WRDI
    } wr_step_t;

endpackage

// File: rtl/spi_byte_tx.sv
// Transmit-only SPI mode 0 byte shifter.
// Assumes: go is only pulsed while idle or in the cycle done is high.
// The clock rests low, each phase lasts CLK_DIV system clocks, data moves on falling edges.
module spi_byte_tx #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       sck,
    output logic       mosi,
    output logic       done
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] PH_LAST = DIV_W'(CLK_DIV - 1);

    logic             active;
    logic [DIV_W-1:0] ph_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sreg;

    // Phase timing, clock toggling and bit shifting for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            ph_cnt  <= '0;
            bit_idx <= '0;
            sreg    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                sreg    <= tx_byte;
                sck     <= 1'b0;
                ph_cnt  <= '0;
                bit_idx <= '0;
            end else if (active) begin
                if (ph_cnt == PH_LAST) begin
                    ph_cnt <= '0;
                    sck    <= ~sck;
                    if (sck) begin
                        if (bit_idx == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            sreg    <= {sreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    ph_cnt <= ph_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign mosi = sreg[7];

endmodule

// File: rtl/busy_watch.sv
// Counts system clocks during a busy wait and flags when the limit is reached.
// Assumes: limit is steady for the length of one wait.
module busy_watch #(
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] wait_cnt;

    // Count up while a wait is running, clear between waits.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wait_cnt <= '0;
        end else if (wait_cnt != limit) begin
            wait_cnt <= wait_cnt + TO_W'(1);
        end
    end

    assign expired = run && (wait_cnt == limit);

endmodule

// File: rtl/flash_pair_writer.sv
// Host-side sequencer that programs consecutive byte pairs into a serial flash
// using the auto-incrementing word-program mode, with ready/busy read on spi_miso.
// Assumes: the target range is erased and unprotected; spi_miso reads 1 when ready
// while chip select is low once ready reporting has been switched on.
module flash_pair_writer
    import flash_pair_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 16,
    parameter int TO_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [TO_W-1:0]   busy_limit,
    input  logic [15:0]       wdata,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    output logic              done,
    output logic              error,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int SUM_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 2;
    localparam logic [SUM_W-1:0] SPACE_END = SUM_W'(1) << ADDR_W;

    wr_state_t            state;
    wr_step_t             step;
    logic [FRAME_W-1:0]   frame_buf;
    logic [2:0]           bytes_left;
    logic [CNT_W-1:0]     words_left;
    logic [ADDR_W-1:0]    addr_q;
    logic                 first_word;
    logic                 err_q;
    logic                 poll_arm;

    logic                 eng_go;
    logic                 eng_done;
    logic                 wait_over;
    logic                 poll_ready;
    logic [SUM_W-1:0]     run_end;
    logic                 range_bad;

    // Request check: even start, non-zero count, run inside the address space.
    always_comb begin
        run_end   = SUM_W'(start_addr) + (SUM_W'(word_count) << 1);
        range_bad = start_addr[0] || (word_count == '0) || (run_end > SPACE_END);
    end

    assign eng_go     = (state == S_SETUP) ||
                        (state == S_SHIFT && eng_done && bytes_left != 3'd0);
    assign poll_ready = (state == S_POLL) && poll_arm && spi_miso;

    assign spi_cs_n    = !(state == S_SHIFT || state == S_POLL);
    assign wdata_ready = (state == S_FETCH);
    assign done        = (state == S_DONE);
    assign error       = (state == S_DONE) && err_q;

    spi_byte_tx #(.CLK_DIV(CLK_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .tx_byte (frame_buf[FRAME_W-1 -: 8]),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (eng_done)
    );

    busy_watch #(.TO_W(TO_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_POLL),
        .limit   (busy_limit),
        .expired (wait_over)
    );

    // Main sequence: command frames, word frames, busy waits and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            step       <= STEP_RB;
            frame_buf  <= '0;
            bytes_left <= '0;
            words_left <= '0;
            addr_q     <= '0;
            first_word <= 1'b0;
            err_q      <= 1'b0;
            poll_arm   <= 1'b0;
        end else begin
            poll_arm <= (state == S_POLL);
            if (eng_go) begin
                frame_buf  <= frame_buf << 8;
                bytes_left <= bytes_left - 3'd1;
            end
            case (state)
                S_IDLE: begin
                    if (start) begin
                        err_q      <= 1'b0;
                        addr_q     <= start_addr;
                        words_left <= word_count;
                        first_word <= 1'b1;
                        if (range_bad) begin
                            err_q <= 1'b1;
                            state <= S_DONE;
                        end else begin
                            step       <= STEP_RB;
                            frame_buf  <= {CMD_RB_LINE, (FRAME_W-8)'(0)};
                            bytes_left <= 3'd1;
                            state      <= S_SETUP;
                        end
                    end
                end
                S_SETUP: state <= S_SHIFT;
                S_SHIFT: begin
                    if (eng_done && bytes_left == 3'd0) state <= S_END;
                end
                S_END: begin
                    case (step)
                        STEP_RB: begin
                            step       <= STEP_WREN;
                            frame_buf  <= {CMD_WR_ON, (FRAME_W-8)'(0)};
                            bytes_left <= 3'd1;
                            state      <= S_SETUP;
                        end
                        STEP_WREN: begin
                            step  <= STEP_PROG;
                            state <= S_FETCH;
                        end
                        STEP_PROG: state <= S_POLL;
                        default:   state <= err_q ? S_DONE : S_POLL;
                    endcase
                end
                S_FETCH: begin
                    if (wdata_valid) begin
                        words_left <= words_left - CNT_W'(1);
                        first_word <= 1'b0;
                        if (first_word) begin
                            frame_buf  <= {CMD_PAIR, addr_q, wdata};
                            bytes_left <= 3'd6;
                        end else begin
                            frame_buf  <= {CMD_PAIR, wdata, (FRAME_W-24)'(0)};
                            bytes_left <= 3'd3;
                        end
                        state <= S_SETUP;
                    end
                end
                S_POLL: begin
                    if (poll_ready || wait_over) begin
                        if (!poll_ready) err_q <= 1'b1;
                        if (step == STEP_PROG && poll_ready && words_left != '0) begin
                            state <= S_FETCH;
                        end else if (step == STEP_PROG) begin
                            step       <= STEP_WRDI;
                            frame_buf  <= {CMD_WR_OFF, (FRAME_W-8)'(0)};
                            bytes_left <= 3'd1;
                            state      <= S_SETUP;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_pair_writer_chk.sv
// Bus-timing and handshake properties for flash_pair_writer, attached by bind.
module flash_pair_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic error,
    input logic wdata_ready,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_ready_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> spi_cs_n);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

endmodule

bind flash_pair_writer flash_pair_writer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .error       (error),
    .wdata_ready (wdata_ready),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi)
);

// File: tb/tb_flash_pair_writer.sv
// Directed bench with a bus-level flash responder that logs commands and writes.
module tb_flash_pair_writer;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 2;
    localparam int CNT_W      = 8;
    localparam int TO_W       = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      start_addr = '0;
    logic [CNT_W-1:0] word_count = '0;
    logic [TO_W-1:0]  busy_limit = TO_W'(100);
    logic [15:0]      wdata = '0;
    logic             wdata_valid = 1'b0;
    logic             wdata_ready, done, error;
    logic             spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;

    flash_pair_writer #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .busy_limit(busy_limit), .wdata(wdata),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .done(done),
        .error(error), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Flash responder state
    int          nbits = 0;
    logic [7:0]  fb [0:7];
    int          cs_falls = 0;
    logic        rb_on = 1'b0;
    logic        wel = 1'b0;
    logic        aai = 1'b0;
    logic [24:0] nxt = '0;
    int          busy_until = 0;
    int          busy_len = 20;
    int          proto_err = 0;
    int          busy_viol = 0;
    logic [7:0]  cmd_log [0:63];
    int          cmd_n = 0;
    logic [23:0] wr_a [0:63];
    logic [7:0]  wr_d [0:63];
    int          wr_n = 0;
    int          mode_err = 0;
    int          hi_run = 0;
    int          hi_min = 9999;
    int          hi_max = 0;

    assign spi_miso = (!spi_cs_n && rb_on && cyc >= busy_until);

    // Bit capture on rising clock, frame start on chip-select fall.
    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (spi_sck) begin
            if (!spi_cs_n && nbits < 64) begin
                fb[nbits/8][7-(nbits%8)] = spi_mosi;
                nbits++;
            end
        end else begin
            nbits = 0;
            cs_falls++;
        end
    end

    // Command execution at the end of each frame.
    always @(posedge spi_cs_n) begin
        if (nbits != 0) begin
            if (cyc < busy_until) busy_viol++;
            if (nbits % 8 != 0) proto_err++;
            cmd_log[cmd_n%64] = fb[0];
            cmd_n++;
            case (fb[0])
                8'h06: wel = 1'b1;
                8'h70: rb_on = 1'b1;
                8'h04: begin wel = 1'b0; aai = 1'b0; busy_until = cyc + 3; end
                8'hAD: begin
                    if (!aai) begin
                        if (!wel || nbits != 48) proto_err++;
                        else begin
                            nxt = {1'b0, fb[1], fb[2], fb[3]};
                            aai = 1'b1;
                            wr_a[wr_n%64] = nxt[23:0];       wr_d[wr_n%64] = fb[4]; wr_n++;
                            wr_a[wr_n%64] = nxt[23:0] + 1;   wr_d[wr_n%64] = fb[5]; wr_n++;
                            nxt = nxt + 2;
                            busy_until = cyc + busy_len;
                        end
                    end else begin
                        if (nbits != 24) proto_err++;
                        else begin
                            wr_a[wr_n%64] = nxt[23:0];       wr_d[wr_n%64] = fb[1]; wr_n++;
                            wr_a[wr_n%64] = nxt[23:0] + 1;   wr_d[wr_n%64] = fb[2]; wr_n++;
                            nxt = nxt + 2;
                            busy_until = cyc + busy_len;
                        end
                    end
                    if (nxt[24]) begin aai = 1'b0; wel = 1'b0; end
                end
                default: proto_err++;
            endcase
        end
    end

    // Data must not move while the clock is high inside a frame.
    always @(spi_mosi) if (spi_sck === 1'b1 && spi_cs_n === 1'b0) mode_err++;

    // Measure clock high phases in system clocks.
    always @(negedge clk) begin
        if (spi_sck === 1'b1) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Launch one request, feed words and wait for done; checks the done pulse.
    task automatic run_req(input logic [23:0] a, input int n, input int feed, input int gap,
                           input logic [15:0] seed, output logic e);
        logic got = 1'b0;
        e = 1'b0;
        @(negedge clk);
        start_addr = a; word_count = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int k = 0; k < feed; k++) begin
                    repeat (gap) @(negedge clk);
                    wdata = seed + 16'(k) * 16'h0101;
                    wdata_valid = 1'b1;
                    while (!wdata_ready) @(negedge clk);
                    @(negedge clk);
                    wdata_valid = 1'b0;
                end
            end
            begin
                for (int i = 0; i < 40000; i++) begin
                    if (done) begin got = 1'b1; e = error; break; end
                    @(negedge clk);
                end
            end
        join
        chk("R10", "done seen", longint'(got), 1);
        chk("R6", "cs high at done", longint'(spi_cs_n), 1);
        @(negedge clk);
        chk("R10", "done one cycle", longint'(done), 0);
        chk("R10", "error after done", longint'(error), 0);
    endtask

    task automatic check_writes(input string req, input int base, input logic [23:0] a,
                                input int n, input logic [15:0] seed);
        chk(req, "write count", wr_n - base, 2*n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = seed + 16'(k) * 16'h0101;
            chk(req, "even addr", wr_a[(base+2*k)%64], a + 24'(2*k));
            chk(req, "even byte", wr_d[(base+2*k)%64], w[15:8]);
            chk(req, "odd addr",  wr_a[(base+2*k+1)%64], a + 24'(2*k+1));
            chk(req, "odd byte",  wr_d[(base+2*k+1)%64], w[7:0]);
        end
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", longint'(spi_cs_n), 1);
        chk("R1", "sck", longint'(spi_sck), 0);
        chk("R1", "done", longint'(done), 0);
        chk("R1", "error", longint'(error), 0);
        chk("R1", "wdata_ready", longint'(wdata_ready), 0);
    endtask

    task automatic t_basic();
        int cb = cmd_n, wb = wr_n, pe = proto_err, bv = busy_viol;
        logic e;
        run_req(24'h000100, 3, 3, 0, 16'hA55A, e);
        chk("R2", "no error", longint'(e), 0);
        chk("R2", "frame count", cmd_n - cb, 6);
        chk("R2", "cmd0 0x70", cmd_log[cb%64], 8'h70);
        chk("R2", "cmd1 0x06", cmd_log[(cb+1)%64], 8'h06);
        chk("R3", "cmd2 0xAD", cmd_log[(cb+2)%64], 8'hAD);
        chk("R4", "cmd3 0xAD", cmd_log[(cb+3)%64], 8'hAD);
        chk("R4", "cmd4 0xAD", cmd_log[(cb+4)%64], 8'hAD);
        chk("R2", "cmd5 0x04", cmd_log[(cb+5)%64], 8'h04);
        chk("R4", "frame lengths", proto_err - pe, 0);
        check_writes("R3", wb, 24'h000100, 3, 16'hA55A);
        chk("R6", "no frame while busy", busy_viol - bv, 0);
        chk("R6", "flash idle at done", longint'(cyc >= busy_until), 1);
        chk("R5", "mosi moved with sck high", mode_err, 0);
        chk("R5", "sck high min", hi_min, CLK_DIV);
        chk("R5", "sck high max", hi_max, CLK_DIV);
        chk("R2", "mode ended", longint'({wel, aai}), 0);
    endtask

    task automatic t_gap();
        int wb = wr_n, bv = busy_viol;
        logic e;
        run_req(24'h00F000, 4, 4, 30, 16'h1234, e);
        chk("R7", "no error", longint'(e), 0);
        check_writes("R7", wb, 24'h00F000, 4, 16'h1234);
        chk("R7", "no frame while busy", busy_viol - bv, 0);
    endtask

    task automatic t_top();
        int wb = wr_n;
        logic e;
        run_req(24'hFFFFFE, 1, 1, 0, 16'hC3E1, e);
        chk("R8", "top run accepted", longint'(e), 0);
        check_writes("R8", wb, 24'hFFFFFE, 1, 16'hC3E1);
    endtask

    task automatic t_reject(input logic [23:0] a, input int n, input string what);
        int cf = cs_falls;
        logic e;
        run_req(a, n, 0, 0, 16'h0, e);
        chk("R8", {what, " error"}, longint'(e), 1);
        chk("R8", {what, " bus quiet"}, cs_falls - cf, 0);
    endtask

    task automatic t_timeout();
        int cb = cmd_n;
        logic e;
        busy_len = 400;
        run_req(24'h002000, 1, 1, 0, 16'h5AA5, e);
        chk("R9", "timeout error", longint'(e), 1);
        chk("R9", "frame count", cmd_n - cb, 4);
        chk("R9", "program sent", cmd_log[(cb+2)%64], 8'hAD);
        chk("R9", "write-disable sent", cmd_log[(cb+3)%64], 8'h04);
        chk("R9", "mode left", longint'({wel, aai}), 0);
        busy_len = 20;
        repeat (500) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_basic();
        t_gap();
        t_top();
        t_reject(24'h000101, 2, "odd address");
        t_reject(24'hFFFFFC, 3, "past top");
        t_reject(24'h000200, 0, "zero count");
        t_timeout();
        t_basic();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule